// File: doc/BRIEF.md
# Gated Clock Fanout with Input Select

This block takes two clocks, a fast system clock and a slower scan or test clock, and picks one of them with a select input. It drives a parameterised number of gated copies of the chosen clock. The default is six copies. Each copy can be forced low by a shared disable input or by its own per-output disable input. It is intended for distributing one clock to several consumers while letting any of them be stopped cleanly.

Disable requests are not applied directly. Each output has a small enable register clocked on the falling edge of the selected clock. A change on a disable input therefore reaches an output only at the next falling edge, while that output is already low. This means a high phase is never cut short, and no extra high pulse is ever started part-way through a phase.

A synchronous, active-high reset is sampled on the same falling edge. It places every enable register in the enabled state.

Top module: `clkfan_top`

## Requirements
- R1: With `sel_test` = 0, every enabled output equals `sys_clk`.
- R2: With `sel_test` = 1, every enabled output equals `test_clk`.
- R3: A falling edge of the selected clock that samples `rst` = 1 enables every output, whatever the disable inputs are.
- R4: A falling edge that samples `dis_all` = 1 holds every output low until a later falling edge samples it at 0.
- R5: Bit i of `dis_each` sampled at 1 holds only `clk_out[i]` low. The other outputs are unaffected.
- R6: A disable change made while the selected clock is high has no effect on any output during that high phase.
- R7: While the selected clock is low, every output is low. An output therefore only starts or stops while low, and every high pulse it produces is a full high phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| sys_clk | input | 1 | System clock, chosen when `sel_test` = 0 |
| test_clk | input | 1 | Scan or test clock, chosen when `sel_test` = 1 |
| sel_test | input | 1 | Clock select; tie to 0 when unused |
| rst | input | 1 | Synchronous active-high reset, sampled on the falling edge of the selected clock |
| dis_all | input | 1 | Shared disable for all outputs |
| dis_each | input | NUM_OUT | Per-output disable, bit i for output i |
| clk_out | output | NUM_OUT | Gated copies of the selected clock |

## Verification
A disable or reset value is captured at the falling edge of the selected clock. Its effect first appears in the high phase that begins at the next rising edge. Output edges themselves follow the clock with no register delay.

The bench changes inputs only 2 ns after a rising edge of the selected clock. It then takes three samples per period:
- 2 ns into the high phase, against the enables captured at the previous falling edge;
- 1 ns after its own change, where the result must still be the old one;
- 2 ns into the low phase, where all outputs must be zero.

The select input is changed only while reset is held, and only after waiting out several periods of the new clock.

// File: rtl/clkfan_pkg.sv
package clkfan_pkg;
  localparam int unsigned DEF_NUM_OUT = 6;
  typedef enum logic {SRC_SYS = 1'b0, SRC_TEST = 1'b1} clk_src_e;
endpackage

// File: rtl/clkfan_sel.sv
module clkfan_sel
  import clkfan_pkg::*;
(
  input  logic main_clk_i,
  input  logic alt_clk_i,
  input  logic sel_i,
  output logic clk_o
);
  clk_src_e src;
  assign src   = clk_src_e'(sel_i);
  assign clk_o = (src == SRC_TEST) ? alt_clk_i : main_clk_i;
endmodule

// File: rtl/clkfan_gate.sv
module clkfan_gate (
  input  logic clk_i,
  input  logic rst_i,
  input  logic dis_shared_i,
  input  logic dis_own_i,
  output logic clk_o
);
  logic en_q;

  always_ff @(negedge clk_i) begin
    if (rst_i) en_q <= 1'b1;
    else       en_q <= ~(dis_shared_i | dis_own_i);
  end

  assign clk_o = clk_i & en_q;
endmodule

// File: rtl/clkfan_top.sv
module clkfan_top
  import clkfan_pkg::*;
#(
  parameter int unsigned NUM_OUT = DEF_NUM_OUT
) (
  input  logic               sys_clk,
  input  logic               test_clk,
  input  logic               sel_test,
  input  logic               rst,
  input  logic               dis_all,
  input  logic [NUM_OUT-1:0] dis_each,
  output logic [NUM_OUT-1:0] clk_out
);
  logic clk_sel;

  clkfan_sel u_sel (
    .main_clk_i (sys_clk),
    .alt_clk_i  (test_clk),
    .sel_i      (sel_test),
    .clk_o      (clk_sel)
  );

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
    clkfan_gate u_gate (
      .clk_i        (clk_sel),
      .rst_i        (rst),
      .dis_shared_i (dis_all),
      .dis_own_i    (dis_each[i]),
      .clk_o        (clk_out[i])
    );
  end
endmodule

// File: rtl/clkfan_chk.sv
module clkfan_chk #(
  parameter int unsigned NUM_OUT = 6
) (
  input logic               sys_clk,
  input logic               test_clk,
  input logic               sel_test,
  input logic               rst,
  input logic               dis_all,
  input logic [NUM_OUT-1:0] dis_each,
  input logic [NUM_OUT-1:0] clk_out
);
  logic ck;
  assign ck = sel_test ? test_clk : sys_clk;

  // R7: just before a rising edge the clock is low, so all outputs are low
  p_low_phase_quiet_r7: assert property (@(posedge ck) disable iff (rst)
    !$isunknown(clk_out) |-> clk_out == '0);

  // R3: a falling edge that saw reset leaves every output enabled
  p_reset_enables_r3: assert property (@(negedge ck) disable iff (rst)
    $past(rst) |-> clk_out == '1);

  // R4: a shared disable captured at the previous falling edge silences all outputs
  p_shared_off_r4: assert property (@(negedge ck) disable iff (rst)
    !$past(rst) && $past(dis_all) |-> clk_out == '0);

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_chk
    // R5: an own disable silences only this output
    p_own_off_r5: assert property (@(negedge ck) disable iff (rst)
      !$past(rst) && $past(dis_each[i]) |-> !clk_out[i]);

    // R1/R2: an output that is not disabled follows the selected clock high
    p_follow_r1: assert property (@(negedge ck) disable iff (rst)
      !$past(rst) && !$past(dis_all) && !$past(dis_each[i]) |-> clk_out[i]);
  end
endmodule

bind clkfan_top clkfan_chk #(.NUM_OUT(NUM_OUT)) u_chk (.*);

// File: tb/clkfan_top_test.sv
`timescale 1ns/100ps
module clkfan_top_test;
  localparam int N = 6;

  logic         sys_clk  = 1'b0;
  logic         test_clk = 1'b0;
  logic         sel_test = 1'b0;
  logic         rst      = 1'b1;
  logic         dis_all  = 1'b0;
  logic [N-1:0] dis_each = '0;
  logic [N-1:0] clk_out;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;
  logic [N-1:0] exp_en = '1;

  always #10 sys_clk  = ~sys_clk;
  always #30 test_clk = ~test_clk;

  logic ref_clk;
  assign ref_clk = sel_test ? test_clk : sys_clk;

  clkfan_top #(.NUM_OUT(N)) uut (
    .sys_clk  (sys_clk),
    .test_clk (test_clk),
    .sel_test (sel_test),
    .rst      (rst),
    .dis_all  (dis_all),
    .dis_each (dis_each),
    .clk_out  (clk_out)
  );

  task automatic check(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  function automatic logic [N-1:0] next_en(input bit r, input bit da, input logic [N-1:0] de);
    return r ? '1 : ~({N{da}} | de);
  endfunction

  task automatic step(input string tag, input bit da, input logic [N-1:0] de);
    @(posedge ref_clk);
    #2;
    check(tag, clk_out, exp_en);
    dis_all  = da;
    dis_each = de;
    #1;
    check("R6 mid-high change ignored", clk_out, exp_en);
    @(negedge ref_clk);
    exp_en = next_en(rst, da, de);
    #2;
    check("R7 low phase quiet", clk_out, '0);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge sys_clk);
    // R3: reset overrides disables
    step("R3 reset enables", 1'b1, '1);
    step("R3 reset enables", 1'b0, '0);
    rst = 1'b0;
    step("R3 reset enables", 1'b1, '0);
    step("R4 shared disable", 1'b0, 6'b000100);
    step("R5 own disable bit2", 1'b0, 6'b100001);
    step("R5 own disable bits0,5", 1'b1, 6'b010000);
    step("R4 shared disable", 1'b0, '0);
    step("R1 restart after disable", 1'b0, '0);
    for (int k = 0; k < 40; k++)
      step("R1 system clock follow", ($urandom % 4) == 0, N'($urandom));
    // switch clock source only under reset
    rst = 1'b1;
    step("R1 system clock follow", 1'b0, '0);
    sel_test = 1'b1;
    repeat (3) @(negedge test_clk);
    exp_en = '1;
    step("R2 test clock after reset", 1'b1, 6'b001000);
    rst = 1'b0;
    step("R3 reset enables", 1'b0, 6'b001000);
    step("R5 own disable bit3", 1'b1, '0);
    step("R4 shared disable", 1'b0, '0);
    for (int k = 0; k < 30; k++)
      step("R2 test clock follow", ($urandom % 4) == 0, N'($urandom));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R1 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule